// File: doc/BRIEF.md
# Parallel Linearized Charge-Balance Duty Controller

This block computes the duty command for a fixed-frequency buck converter that runs in discontinuous conduction mode. Once per switching period a strobe delivers three signed samples: input voltage, output voltage and reference voltage. Each sample feeds its own two-tap linear path. A path weights the present sample and the sample from the previous strobe with signed fixed-point coefficients. The three path results are summed, scaled back to whole clock counts, offset by a constant operating-point duty, and clamped. The datapath uses no division and no square root, and the three paths are evaluated side by side in the same clock cycles.

The result is computed one period ahead. A fresh duty value waits in a pending register and only takes effect at the next period boundary, where it drives a counter-based PWM output. Software loads the six coefficients and the offset through a small select/data write port. The default setting of 2000 counts per period gives a 100 kHz switching frequency from a 200 MHz clock.

Top module: `lincb_duty_ctrl`

## Requirements
- R1: Each of the three paths (input, output, reference) produces y = c_now*x[n] + c_old*x[n-1]. The coefficients are signed with CFRAC fraction bits. x[n-1] is the sample captured at the previous strobe, and is zero after reset. The history advances only on a strobe and ignores sample inputs between strobes.
- R2: calc_done is high for exactly one cycle, three clock edges after the edge that samples sample_valid. In that same cycle duty_next holds the new result.
- R3: duty_next = floor((y_in + y_out + y_ref) / 2^CFRAC) + offset. The floor rounds toward minus infinity, and the offset is a signed value in clock counts.
- R4: The summed duty saturates to the range 0 to PERIOD-1.
- R5: A write with cfg_we high stores cfg_wdata in the slot picked by cfg_sel: 0 input/now, 1 input/previous, 2 output/now, 3 output/previous, 4 reference/now, 5 reference/previous, 6 offset. Select value 7 changes nothing. All slots reset to zero.
- R6: duty_live takes the value of duty_next only on the edge that ends a period, and it holds at all other times.
- R7: pwm_out is high while the free-running period counter (0 to PERIOD-1) is below duty_live. Any window of PERIOD clocks under a steady duty therefore contains exactly duty_live high cycles.
- R8: Reset clears the history, the pipeline and both duty registers, so that calc_done, duty_next, duty_live and pwm_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe marking fresh samples |
| vin_s | input | DW | Signed input-voltage sample |
| vout_s | input | DW | Signed output-voltage sample |
| vref_s | input | DW | Signed reference-voltage sample |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration slot select |
| cfg_wdata | input | CW | Signed coefficient or offset value |
| calc_done | output | 1 | Pulse when a new duty is ready |
| duty_next | output | PCW | Pending duty for the next period |
| duty_live | output | PCW | Duty applied in the present period |
| pwm_out | output | 1 | PWM switch drive |

## Verification
A lone offset with all coefficients at zero isolates the scaling, the pending-to-live hand-over and the PWM width from the arithmetic paths. Single-path tests with a nonzero previous-sample tap separate the current term from the history term. They also show whether junk driven between strobes leaks into the history. A mixed-sign run through all three paths checks the sum. A one-LSB negative product checks that the scaling floors rather than truncating toward zero. Drives far above and below the range tell the two clamps apart, and a write to the unused select shows that no slot was disturbed.

// File: rtl/lincb_pkg.sv
package lincb_pkg;

    localparam int NPATH = 3;
    localparam int NTAP  = 2;

    typedef enum logic [2:0] {
        SEL_VIN_NOW  = 3'd0,
        SEL_VIN_OLD  = 3'd1,
        SEL_VOUT_NOW = 3'd2,
        SEL_VOUT_OLD = 3'd3,
        SEL_VREF_NOW = 3'd4,
        SEL_VREF_OLD = 3'd5,
        SEL_OFFSET   = 3'd6,
        SEL_NONE     = 3'd7
    } cfg_sel_e;

    function automatic int sel_path(input logic [2:0] s);
        return int'(s[2:1]);
    endfunction

    function automatic int sel_tap(input logic [2:0] s);
        return int'(s[0]);
    endfunction

endpackage

// File: rtl/lincb_path.sv
module lincb_path #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int PW = DW + CW,
    parameter int SW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x,
    input  logic signed [CW-1:0] c_now,
    input  logic signed [CW-1:0] c_old,
    output logic                 out_valid,
    output logic signed [SW-1:0] psum
);
    typedef struct packed {
        logic                 vld;
        logic signed [PW-1:0] p_now;
        logic signed [PW-1:0] p_old;
    } prod_t;

    logic signed [DW-1:0] hist_q;
    prod_t                st1_q;
    logic signed [SW-1:0] psum_q;
    logic                 vld2_q;

    logic signed [PW-1:0] x_e, h_e, cn_e, co_e;
    assign x_e  = PW'(x);
    assign h_e  = PW'(hist_q);
    assign cn_e = PW'(c_now);
    assign co_e = PW'(c_old);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            st1_q  <= '0;
            psum_q <= '0;
            vld2_q <= 1'b0;
        end else begin
            st1_q.vld <= in_valid;
            if (in_valid) begin
                hist_q      <= x;
                st1_q.p_now <= x_e * cn_e;
                st1_q.p_old <= h_e * co_e;
            end
            vld2_q <= st1_q.vld;
            if (st1_q.vld)
                psum_q <= SW'(st1_q.p_now) + SW'(st1_q.p_old);
        end
    end

    assign out_valid = vld2_q;
    assign psum      = psum_q;
endmodule

// File: rtl/lincb_merge.sv
module lincb_merge #(
    parameter int SW     = 33,
    parameter int CW     = 16,
    parameter int CFRAC  = 12,
    parameter int PERIOD = 2000,
    parameter int PCW    = $clog2(PERIOD),
    parameter int NP     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] ps [NP],
    input  logic signed [CW-1:0] offset,
    output logic                 done,
    output logic [PCW-1:0]       duty
);
    localparam int AW = SW + 2 + ((CW > SW) ? CW : 0);
    localparam logic signed [AW-1:0] DMAX = AW'(PERIOD - 1);

    logic signed [AW-1:0] acc, scaled;
    logic [PCW-1:0]       sat;
    logic                 done_q;
    logic [PCW-1:0]       duty_q;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NP; k++)
            acc = acc + AW'(ps[k]);
        scaled = (acc >>> CFRAC) + AW'(offset);
        if (scaled < 0)
            sat = '0;
        else if (scaled > DMAX)
            sat = PCW'(PERIOD - 1);
        else
            sat = scaled[PCW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            duty_q <= '0;
        end else begin
            done_q <= in_valid;
            if (in_valid)
                duty_q <= sat;
        end
    end

    assign done = done_q;
    assign duty = duty_q;
endmodule

// File: rtl/lincb_pwm.sv
module lincb_pwm #(
    parameter int PERIOD = 2000,
    parameter int PCW    = $clog2(PERIOD)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [PCW-1:0] duty_in,
    output logic [PCW-1:0] duty_live,
    output logic [PCW-1:0] cnt,
    output logic           pwm_out
);
    localparam logic [PCW-1:0] LAST = PCW'(PERIOD - 1);

    logic [PCW-1:0] cnt_q, live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            live_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            live_q <= duty_in;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign cnt       = cnt_q;
    assign duty_live = live_q;
    assign pwm_out   = (cnt_q < live_q);
endmodule

// File: rtl/lincb_duty_ctrl.sv
module lincb_duty_ctrl
    import lincb_pkg::*;
#(
    parameter int DW     = 16,
    parameter int CW     = 16,
    parameter int CFRAC  = 12,
    parameter int PERIOD = 2000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sample_valid,
    input  logic signed [DW-1:0]          vin_s,
    input  logic signed [DW-1:0]          vout_s,
    input  logic signed [DW-1:0]          vref_s,
    input  logic                          cfg_we,
    input  logic [2:0]                    cfg_sel,
    input  logic signed [CW-1:0]          cfg_wdata,
    output logic                          calc_done,
    output logic [$clog2(PERIOD)-1:0]     duty_next,
    output logic [$clog2(PERIOD)-1:0]     duty_live,
    output logic                          pwm_out
);
    localparam int PCW = $clog2(PERIOD);
    localparam int PW  = DW + CW;
    localparam int SW  = PW + 1;

    logic signed [CW-1:0] coef_q [NPATH][NTAP];
    logic signed [CW-1:0] offset_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPATH; p++)
                for (int t = 0; t < NTAP; t++)
                    coef_q[p][t] <= '0;
            offset_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_OFFSET)
                offset_q <= cfg_wdata;
            else if (cfg_sel != SEL_NONE)
                coef_q[sel_path(cfg_sel)][sel_tap(cfg_sel)] <= cfg_wdata;
        end
    end

    logic signed [DW-1:0] samp [NPATH];
    assign samp[0] = vin_s;
    assign samp[1] = vout_s;
    assign samp[2] = vref_s;

    logic signed [SW-1:0] psum [NPATH];
    logic [NPATH-1:0]     pvld;

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        lincb_path #(.DW(DW), .CW(CW), .PW(PW), .SW(SW)) i_path (
            .clk      (clk),
            .rst      (rst),
            .in_valid (sample_valid),
            .x        (samp[g]),
            .c_now    (coef_q[g][0]),
            .c_old    (coef_q[g][1]),
            .out_valid(pvld[g]),
            .psum     (psum[g])
        );
    end

    lincb_merge #(.SW(SW), .CW(CW), .CFRAC(CFRAC), .PERIOD(PERIOD),
                  .PCW(PCW), .NP(NPATH)) i_merge (
        .clk     (clk),
        .rst     (rst),
        .in_valid(pvld[0]),
        .ps      (psum),
        .offset  (offset_q),
        .done    (calc_done),
        .duty    (duty_next)
    );

    logic [PCW-1:0] pwm_cnt;

    lincb_pwm #(.PERIOD(PERIOD), .PCW(PCW)) i_pwm (
        .clk      (clk),
        .rst      (rst),
        .duty_in  (duty_next),
        .duty_live(duty_live),
        .cnt      (pwm_cnt),
        .pwm_out  (pwm_out)
    );
endmodule

// File: rtl/lincb_duty_ctrl_chk.sv
module lincb_duty_ctrl_chk #(
    parameter int PERIOD = 2000,
    parameter int PCW    = $clog2(PERIOD)
) (
    input logic           clk,
    input logic           rst,
    input logic           sample_valid,
    input logic           calc_done,
    input logic [PCW-1:0] duty_next,
    input logic [PCW-1:0] duty_live,
    input logic           pwm_out,
    input logic [PCW-1:0] cnt
);
    localparam logic [PCW-1:0] LAST = PCW'(PERIOD - 1);

    // R2
    a_r2_done_latency: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> ##3 calc_done);

    // R4
    a_r4_range: assert property (@(posedge clk) disable iff (rst)
        (duty_next <= LAST) && (duty_live <= LAST));

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt != LAST) |=> $stable(duty_live));

    // R6
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> (duty_live == $past(duty_next)));

    // R7
    a_r7_zero_low: assert property (@(posedge clk) disable iff (rst)
        (duty_live == '0) |-> !pwm_out);

    // R7
    a_r7_start_high: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && duty_live != '0) |-> pwm_out);
endmodule

bind lincb_duty_ctrl lincb_duty_ctrl_chk #(.PERIOD(PERIOD), .PCW(PCW)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_valid(sample_valid),
    .calc_done   (calc_done),
    .duty_next   (duty_next),
    .duty_live   (duty_live),
    .pwm_out     (pwm_out),
    .cnt         (pwm_cnt)
);

// File: tb/test_lincb_duty_ctrl.sv
`timescale 1ns/1ps
module test_lincb_duty_ctrl;
    localparam int DW = 16, CW = 16, CFRAC = 12, PERIOD = 2000;
    localparam int PCW = $clog2(PERIOD);

    logic clk = 1'b0, rst = 1'b1;
    logic sample_valid = 1'b0, cfg_we = 1'b0;
    logic signed [DW-1:0] vin_s = '0, vout_s = '0, vref_s = '0;
    logic [2:0] cfg_sel = '0;
    logic signed [CW-1:0] cfg_wdata = '0;
    logic calc_done, pwm_out;
    logic [PCW-1:0] duty_next, duty_live;

    int total = 0, bad = 0, cyc = 0;
    longint m_coef [6];
    longint m_off;
    longint m_hist [3];

    always #2.5 clk = ~clk;

    lincb_duty_ctrl #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .PERIOD(PERIOD)) i_lincb_duty_ctrl (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .vin_s(vin_s), .vout_s(vout_s), .vref_s(vref_s),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .calc_done(calc_done), .duty_next(duty_next),
        .duty_live(duty_live), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=200000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input longint val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = CW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 3'd6) m_coef[sel] = val;
        else if (sel == 3'd6) m_off = val;
    endtask

    function automatic longint model(input longint a, input longint b, input longint c);
        longint x [3];
        longint s, v;
        x[0] = a; x[1] = b; x[2] = c;
        s = 0;
        for (int p = 0; p < 3; p++)
            s += m_coef[2*p] * x[p] + m_coef[2*p+1] * m_hist[p];
        v = (s >>> CFRAC) + m_off;
        if (v < 0) v = 0;
        if (v > PERIOD - 1) v = PERIOD - 1;
        return v;
    endfunction

    // R1 R2 R3: strobe samples and check the latency and the result
    task automatic do_sample(input string req, input longint a, input longint b, input longint c);
        longint exp;
        exp = model(a, b, c);
        @(negedge clk);
        vin_s = DW'(a); vout_s = DW'(b); vref_s = DW'(c); sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        vin_s = 16'sh1234; vout_s = -16'sd999; vref_s = 16'sh0777;
        check({req, " R2 done early"}, calc_done, 0);
        @(negedge clk);
        check({req, " R2 done early"}, calc_done, 0);
        @(negedge clk);
        check({req, " R2 done"}, calc_done, 1);
        check(req, duty_next, exp);
        @(negedge clk);
        check({req, " R2 one-cycle done"}, calc_done, 0);
        m_hist[0] = a; m_hist[1] = b; m_hist[2] = c;
    endtask

    // R7: count high cycles over one full period once the duty is steady
    task automatic pwm_width(input string req, input longint exp);
        int hi;
        repeat (PERIOD + 2) @(negedge clk);
        check({req, " R6 live"}, duty_live, exp);
        hi = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check({req, " R7 width"}, hi, exp);
    endtask

    task automatic t_reset;
        int hi;
        check("R8 done", calc_done, 0);
        check("R8 duty_next", duty_next, 0);
        check("R8 duty_live", duty_live, 0);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check("R8 pwm low", hi, 0);
    endtask

    task automatic t_offset;
        cfg_write(3'd6, 500);
        do_sample("R3 offset only", 0, 0, 0);
        check("R6 not yet applied", duty_live, 0);
        pwm_width("R3 offset", 500);
    endtask

    task automatic t_vin;
        cfg_write(3'd0, 4096);
        cfg_write(3'd1, 2048);
        do_sample("R1 vin first", 300, 0, 0);
        do_sample("R1 vin history", 100, 0, 0);
        do_sample("R1 vin negative", -200, 0, 0);
    endtask

    task automatic t_mixed;
        cfg_write(3'd2, -8192);
        cfg_write(3'd3, 1024);
        cfg_write(3'd4, 6144);
        cfg_write(3'd5, -2048);
        do_sample("R1 mixed a", 250, 120, 400);
        do_sample("R1 mixed b", 180, -60, 410);
        pwm_width("R1 mixed", model(0, 0, 0) == 0 ? 0 : duty_next);
    endtask

    task automatic t_floor;
        for (int s = 0; s < 6; s++) cfg_write(3'(s), 0);
        cfg_write(3'd0, -1);
        cfg_write(3'd6, 10);
        do_sample("R3 floor", 1, 0, 0);
        check("R3 floor value", duty_next, 9);
    endtask

    task automatic t_sat;
        cfg_write(3'd0, 4096);
        cfg_write(3'd6, 0);
        do_sample("R4 clamp high", 30000, 0, 0);
        check("R4 clamp high value", duty_next, PERIOD - 1);
        pwm_width("R4 clamp high", PERIOD - 1);
        do_sample("R4 clamp low", -30000, 0, 0);
        check("R4 clamp low value", duty_next, 0);
        pwm_width("R4 clamp low", 0);
    endtask

    task automatic t_sel;
        cfg_write(3'd7, 1234);
        cfg_write(3'd6, 40);
        do_sample("R5 select 7 ignored", 700, 0, 0);
        check("R5 select 7 value", duty_next, 740);
        cfg_write(3'd1, 4096);
        do_sample("R5 previous-tap slot", 0, 0, 0);
        check("R5 previous-tap value", duty_next, 740);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) m_coef[i] = 0;
        for (int i = 0; i < 3; i++) m_hist[i] = 0;
        m_off = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_offset();
        t_vin();
        t_mixed();
        t_floor();
        t_sat();
        t_sel();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule